// File: doc/BRIEF.md
# Iterative Integer Divider

This block divides one 32-bit integer by another and returns the quotient. It works one quotient bit per clock cycle with a restoring shift-and-subtract loop. A single command word picks signed or unsigned division. The caller pulses a start strobe together with the two operands and the command. The unit then stays busy for a fixed number of cycles. It ends with a one-cycle completion strobe, and the quotient register keeps its value until the next command completes.

Signed division is done on the operand magnitudes. The quotient is negated at the end only when the operand signs differ, so it is truncated toward zero. The dividend and the quotient share one shift register: quotient bits enter at the bottom as dividend bits leave at the top. The partial remainder is kept internally and is not brought out. A zero divisor does not stop or shorten the run. It completes in the usual number of cycles, and a flag is raised alongside the completion strobe.

Top module: `iter_divider`

## Requirements
- R1: A start with command code 0x24 (unsigned) or 0x25 (signed) while the unit is idle is accepted, and `busy_o` is high in the next cycle. A start with any other command code is ignored: `busy_o` stays low and no completion follows.
- R2: `done_o` is high for exactly one cycle, 33 clock edges after the accepting edge (DATA_W + 1). It is high in the first cycle that `busy_o` is low again, and `busy_o` is never high together with `done_o`.
- R3: A start pulse while `busy_o` is high is ignored. The running result is unchanged and no extra completion is produced.
- R4: For code 0x24, the quotient is the unsigned floor of dividend divided by divisor.
- R5: For code 0x25, the quotient is the quotient of the two operand magnitudes. It is negated (two's complement) when the sign bits of the two operands differ, so it is truncated toward zero.
- R6: A signed dividend of 0x80000000 is handled as the magnitude 0x80000000. Dividing it by -1 or by 1 gives 0x80000000, and dividing it by 2 gives 0xC0000000.
- R7: A zero divisor completes in the normal cycle count with `div_by_zero_o` high in the `done_o` cycle; `div_by_zero_o` is never high outside a `done_o` cycle. The unsigned quotient is 0xFFFFFFFF. The signed quotient is 0xFFFFFFFF for a non-negative dividend and 0x00000001 for a negative one.
- R8: `quotient_o` changes only in a `done_o` cycle. It holds its value afterwards, including through the next run, until that run completes.
- R9: After a synchronous reset, `busy_o`, `done_o`, `div_by_zero_o` and `quotient_o` are all zero.
- R10: A start presented in the cycle where `done_o` is high is accepted, so commands can follow each other with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Command strobe, sampled on the rising edge |
| opcode_i | input | 6 | Command code: 0x25 signed, 0x24 unsigned |
| dividend_i | input | 32 | Dividend, sampled with the strobe |
| divisor_i | input | 32 | Divisor, sampled with the strobe |
| busy_o | output | 1 | High while a division is running |
| done_o | output | 1 | One-cycle completion strobe |
| quotient_o | output | 32 | Quotient register, held between completions |
| div_by_zero_o | output | 1 | High with done_o when the divisor was zero |

## Verification
The hardest cases to reach are a start that arrives mid-run and a start that arrives in the completion cycle itself. Both depend on the exact cycle the strobe lands in, so the driver counts negative edges from the accepting edge and places the strobe there: ten cycles into a run for the ignored case, and on the `done_o` cycle for the back-to-back case. The most negative dividend and zero divisors in both modes are driven explicitly. Random operands are then mixed with small divisors, so that quotients with many set bits exercise the compare-and-subtract path.

// File: rtl/iter_div_pkg.sv
package iter_div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;

  localparam int unsigned CMD_W        = 6;
  localparam logic [CMD_W-1:0] CMD_SDIV = 6'h25;
  localparam logic [CMD_W-1:0] CMD_UDIV = 6'h24;

endpackage

// File: rtl/iter_div_ctrl.sv
module iter_div_ctrl
  import iter_div_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic cmd_ok_i,
  output logic load_o,
  output logic step_o,
  output logic finish_o,
  output logic busy_o
);

  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DATA_W - 1);

  div_state_e       state_q;
  logic [CNT_W-1:0] step_cnt_q;

  assign load_o   = start_i && cmd_ok_i && (state_q == ST_IDLE);
  assign step_o   = (state_q == ST_RUN);
  assign finish_o = (state_q == ST_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      step_cnt_q <= '0;
      busy_o     <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (load_o) begin
            state_q    <= ST_RUN;
            step_cnt_q <= '0;
            busy_o     <= 1'b1;
          end
        end
        ST_RUN: begin
          step_cnt_q <= step_cnt_q + 1'b1;
          if (step_cnt_q == LAST_STEP) begin
            state_q <= ST_FIN;
          end
        end
        ST_FIN: begin
          state_q <= ST_IDLE;
          busy_o  <= 1'b0;
        end
        default: begin
          state_q <= ST_IDLE;
          busy_o  <= 1'b0;
        end
      endcase
    end
  end

  // R2: the busy flag tracks the sequencer leaving and re-entering idle
  assert_busy_tracks_state_R2: assert property (@(posedge clk) disable iff (rst)
    busy_o == (state_q != ST_IDLE));

  // R3: no new load while a run is in progress
  assert_no_load_when_busy_R3: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !load_o);

  // R2: a run always reaches the finishing state after its last step
  assert_last_step_finishes_R2: assert property (@(posedge clk) disable iff (rst)
    (step_o && step_cnt_q == LAST_STEP) |=> finish_o);

endmodule

// File: rtl/iter_div_prep.sv
module iter_div_prep #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              signed_i,
  input  logic [DATA_W-1:0] dividend_i,
  input  logic [DATA_W-1:0] divisor_i,
  output logic [DATA_W-1:0] mag_a_o,
  output logic [DATA_W-1:0] mag_b_o,
  output logic              neg_q_o
);

  logic neg_a;
  logic neg_b;

  assign neg_a = signed_i && dividend_i[DATA_W-1];
  assign neg_b = signed_i && divisor_i[DATA_W-1];

  // The most negative value negates to itself, which read unsigned is its magnitude.
  assign mag_a_o = neg_a ? (~dividend_i + 1'b1) : dividend_i;
  assign mag_b_o = neg_b ? (~divisor_i + 1'b1) : divisor_i;
  assign neg_q_o = neg_a ^ neg_b;

endmodule

// File: rtl/iter_div_core.sv
module iter_div_core #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] mag_a_i,
  input  logic [DATA_W-1:0] mag_b_i,
  input  logic              neg_q_i,
  output logic [DATA_W-1:0] quot_o,
  output logic              neg_q_o,
  output logic              div_zero_o
);

  localparam int unsigned WIDE_W = DATA_W + 1;

  logic [DATA_W-1:0] shreg_q;
  logic [DATA_W-1:0] rem_q;
  logic [DATA_W-1:0] dvsr_q;
  logic              neg_q;

  logic [WIDE_W-1:0] rem_shift;
  logic [WIDE_W-1:0] rem_diff;
  logic              fits;

  assign rem_shift = {rem_q, shreg_q[DATA_W-1]};
  assign fits      = (rem_shift >= {1'b0, dvsr_q});
  assign rem_diff  = rem_shift - {1'b0, dvsr_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      rem_q   <= '0;
      dvsr_q  <= '0;
      neg_q   <= 1'b0;
    end else if (load_i) begin
      shreg_q <= mag_a_i;
      rem_q   <= '0;
      dvsr_q  <= mag_b_i;
      neg_q   <= neg_q_i;
    end else if (step_i) begin
      shreg_q <= {shreg_q[DATA_W-2:0], fits};
      rem_q   <= fits ? rem_diff[DATA_W-1:0] : rem_shift[DATA_W-1:0];
    end
  end

  assign quot_o     = shreg_q;
  assign neg_q_o    = neg_q;
  assign div_zero_o = (dvsr_q == '0);

  // R4: after every step the partial remainder is below a nonzero divisor
  assert_rem_below_divisor_R4: assert property (@(posedge clk) disable iff (rst)
    step_i |=> (dvsr_q == '0 || rem_q < dvsr_q));

  // R3: the divisor is frozen while the loop steps
  assert_divisor_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i) |=> $stable(dvsr_q));

endmodule

// File: rtl/iter_div_fix.sv
module iter_div_fix #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              finish_i,
  input  logic [DATA_W-1:0] quot_i,
  input  logic              neg_q_i,
  input  logic              div_zero_i,
  output logic [DATA_W-1:0] quotient_o,
  output logic              done_o,
  output logic              div_by_zero_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      quotient_o    <= '0;
      done_o        <= 1'b0;
      div_by_zero_o <= 1'b0;
    end else begin
      done_o        <= finish_i;
      div_by_zero_o <= finish_i && div_zero_i;
      if (finish_i) begin
        quotient_o <= neg_q_i ? (~quot_i + 1'b1) : quot_i;
      end
    end
  end

  // R2: completion strobe lasts a single cycle
  assert_done_single_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7: zero-divisor flag only accompanies the completion strobe
  assert_dbz_with_done_R7: assert property (@(posedge clk) disable iff (rst)
    div_by_zero_o |-> done_o);

  // R8: the result register moves only on completion
  assert_quot_held_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(quotient_o) |-> done_o);

endmodule

// File: rtl/iter_divider.sv
module iter_divider
  import iter_div_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CMD_W-1:0]  opcode_i,
  input  logic [DATA_W-1:0] dividend_i,
  input  logic [DATA_W-1:0] divisor_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] quotient_o,
  output logic              div_by_zero_o
);

  logic              cmd_signed;
  logic              cmd_ok;
  logic              load;
  logic              step;
  logic              finish;
  logic [DATA_W-1:0] mag_a;
  logic [DATA_W-1:0] mag_b;
  logic              neg_q_in;
  logic [DATA_W-1:0] quot_raw;
  logic              neg_q_run;
  logic              div_zero;

  assign cmd_signed = (opcode_i == CMD_SDIV);
  assign cmd_ok     = cmd_signed || (opcode_i == CMD_UDIV);

  iter_div_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .cmd_ok_i (cmd_ok),
    .load_o   (load),
    .step_o   (step),
    .finish_o (finish),
    .busy_o   (busy_o)
  );

  iter_div_prep #(.DATA_W(DATA_W)) prep_i (
    .signed_i   (cmd_signed),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .mag_a_o    (mag_a),
    .mag_b_o    (mag_b),
    .neg_q_o    (neg_q_in)
  );

  iter_div_core #(.DATA_W(DATA_W)) core_i (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .step_i     (step),
    .mag_a_i    (mag_a),
    .mag_b_i    (mag_b),
    .neg_q_i    (neg_q_in),
    .quot_o     (quot_raw),
    .neg_q_o    (neg_q_run),
    .div_zero_o (div_zero)
  );

  iter_div_fix #(.DATA_W(DATA_W)) fix_i (
    .clk           (clk),
    .rst           (rst),
    .finish_i      (finish),
    .quot_i        (quot_raw),
    .neg_q_i       (neg_q_run),
    .div_zero_i    (div_zero),
    .quotient_o    (quotient_o),
    .done_o        (done_o),
    .div_by_zero_o (div_by_zero_o)
  );

  // R2: busy and done never overlap
  assert_busy_done_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));

  // R2: a run ends only through the completion strobe
  assert_busy_ends_in_done_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  // R1: an accepted command raises busy on the next cycle
  assert_accept_sets_busy_R1: assert property (@(posedge clk) disable iff (rst)
    (start_i && cmd_ok && !busy_o) |=> busy_o);

endmodule

// File: tb/iter_divider_tb_top.sv
module iter_divider_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LATENCY    = 33;
  localparam logic [5:0] OP_S = 6'h25;
  localparam logic [5:0] OP_U = 6'h24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [5:0]  opcode_i = '0;
  logic [31:0] dividend_i = '0;
  logic [31:0] divisor_i = '0;
  logic        busy_o;
  logic        done_o;
  logic [31:0] quotient_o;
  logic        div_by_zero_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] last_q = '0;

  typedef struct {
    logic [31:0] q;
    logic        dbz;
    int          acc_cyc;
    string       req;
  } exp_t;

  exp_t sb[$];

  iter_divider dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .opcode_i(opcode_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i), .busy_o(busy_o),
    .done_o(done_o), .quotient_o(quotient_o), .div_by_zero_o(div_by_zero_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_q(input logic [5:0] op, input logic [31:0] a,
                                          input logic [31:0] b);
    logic [31:0] ma, mb, q;
    if (op == OP_S) begin
      ma = a[31] ? -a : a;
      mb = b[31] ? -b : b;
      q  = (mb == 0) ? 32'hFFFF_FFFF : ma / mb;
      if (a[31] ^ b[31]) q = -q;
    end else begin
      q = (b == 0) ? 32'hFFFF_FFFF : a / b;
    end
    return q;
  endfunction

  // Driver: present a command at a negative edge; push its expectation
  task automatic issue(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b,
                       input string req);
    exp_t e;
    e.q = model_q(op, a, b);
    e.dbz = (b == 0);
    e.acc_cyc = cyc + 1;
    e.req = req;
    sb.push_back(e);
    start_i = 1'b1; opcode_i = op; dividend_i = a; divisor_i = b;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R1", "busy after accept", 32'(busy_o), 32'd1);
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  task automatic run(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b,
                     input string req);
    wait_idle();
    issue(op, a, b, req);
    wait_idle();
    @(negedge clk);
  endtask

  // Monitor: pop and compare on each completion
  always @(negedge clk) begin
    if (!rst && done_o) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R3", "unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(quotient_o == e.q, e.req, "quotient", quotient_o, e.q);
        chk(div_by_zero_o == e.dbz, "R7", "div_by_zero flag", 32'(div_by_zero_o), 32'(e.dbz));
        chk(cyc - e.acc_cyc == LATENCY, "R2", "latency", 32'(cyc - e.acc_cyc), 32'(LATENCY));
        chk(busy_o == 1'b0, "R2", "busy low with done", 32'(busy_o), 32'd0);
        last_q = e.q;
      end
    end
  end

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9: reset state
    chk(busy_o == 0, "R9", "busy in reset", 32'(busy_o), 0);
    chk(done_o == 0, "R9", "done in reset", 32'(done_o), 0);
    chk(quotient_o == 0, "R9", "quotient in reset", quotient_o, 0);
    chk(div_by_zero_o == 0, "R9", "dbz in reset", 32'(div_by_zero_o), 0);
    rst = 1'b0;
    @(negedge clk);

    // R4: unsigned basics
    run(OP_U, 32'd43, 32'd7, "R4");
    run(OP_U, 32'hFFFF_FFFF, 32'd1, "R4");
    run(OP_U, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4");
    run(OP_U, 32'd5, 32'd9, "R4");
    run(OP_U, 32'h8000_0000, 32'hFFFF_FFFF, "R4");

    // R5: signed, each sign combination
    run(OP_S, 32'd100, 32'd7, "R5");
    run(OP_S, -32'd100, 32'd7, "R5");
    run(OP_S, 32'd100, -32'd7, "R5");
    run(OP_S, -32'd100, -32'd7, "R5");
    run(OP_S, -32'd3, 32'd5, "R5");

    // R6: most negative dividend
    run(OP_S, 32'h8000_0000, 32'hFFFF_FFFF, "R6");
    run(OP_S, 32'h8000_0000, 32'd1, "R6");
    run(OP_S, 32'h8000_0000, 32'd2, "R6");

    // R7: zero divisor in both modes
    run(OP_U, 32'd12345, 32'd0, "R7");
    run(OP_S, 32'd12345, 32'd0, "R7");
    run(OP_S, -32'd12345, 32'd0, "R7");

    // R1: unknown command is ignored
    wait_idle();
    start_i = 1'b1; opcode_i = 6'h27; dividend_i = 32'd9; divisor_i = 32'd3;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 0, "R1", "busy after bad command", 32'(busy_o), 0);
    repeat (40) @(negedge clk);
    chk(busy_o == 0, "R1", "still idle after bad command", 32'(busy_o), 0);

    // R8: result held after completion and through the next run
    chk(quotient_o == last_q, "R8", "held after done", quotient_o, last_q);
    issue(OP_U, 32'd1000, 32'd10, "R8");
    repeat (10) @(negedge clk);
    chk(quotient_o == last_q, "R8", "held during next run", quotient_o, last_q);

    // R3: start while busy is ignored
    start_i = 1'b1; opcode_i = OP_U; dividend_i = 32'd77; divisor_i = 32'd1;
    @(negedge clk);
    start_i = 1'b0;
    wait_idle();
    repeat (40) @(negedge clk);
    chk(busy_o == 0, "R3", "no run from busy start", 32'(busy_o), 0);
    chk(quotient_o == 32'd100, "R3", "result unaffected", quotient_o, 32'd100);

    // R10: back-to-back start on the done cycle
    issue(OP_S, -32'd50, 32'd5, "R10");
    wait_idle();
    chk(done_o == 1, "R10", "at done cycle", 32'(done_o), 1);
    issue(OP_U, 32'd81, 32'd9, "R10");
    wait_idle();
    @(negedge clk);

    // R4 / R5: random patterns with varied divisor sizes
    for (int i = 0; i < 60; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = $urandom;
      if (i % 3 == 0) b = b >> 20;
      if (i % 4 == 1) b = b >> 28;
      if (i % 2 == 0) run(OP_U, a, b, "R4");
      else            run(OP_S, a, (i % 5 == 0) ? -b : b, "R5");
    end

    repeat (5) @(negedge clk);
    chk(sb.size() == 0, "R2", "all results returned", 32'(sb.size()), 0);
    finish_up();
  end

endmodule